// File: doc/BRIEF.md
# Fractional-Divider PWM Timebase

This block generates the shared count that a group of PWM channels compares against. A per-cycle enable pulse comes from one of two tick sources, picked by a select input. The pulse feeds a phase accumulator that divides the tick rate by a fixed-point value with 8 fraction bits. Each time the accumulator crosses the divide threshold, it advances a counter by one. The counter wraps after reaching 2^lim - 1, where lim is a programmable exponent.

The divide value and the wrap exponent are not applied at once. Software presents them on the inputs and pulses an update strobe, which stages them. The staged pair takes effect at the next wrap of the counter, or at the next forced clear of the counter, whichever comes first. This keeps a PWM period from being cut short or stretched partway through.

Each wrap sets a sticky overflow flag. The flag is masked by an enable to give a status output, and a clear strobe resets it. A registered copy of the count is provided for a register-read path.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count, the registered count copy, the overflow flag and the status output are all 0. The active settings start at an exponent of 20 and a divide value of 256 (divide by 1.0).
- R2: The tick source is chosen by `src_sel_i`: 1 selects `tick_fast_i` and 0 selects `tick_ref_i`. Pulses on the source that is not selected never move the count.
- R3: The divide value is unsigned fixed point with its low 8 bits as the fraction. Each selected tick adds 256 to a phase accumulator. When the accumulator reaches or exceeds the active divide value D, the count advances by one and D is subtracted. Starting from a cleared phase, N ticks therefore advance the count by floor(N*256/D). A D below 256 behaves as 256.
- R4: With an active exponent L, the count runs 0, 1, …, 2^L-1 and then returns to 0 on the next advance. With L = 0 the count stays at 0.
- R5: While `pause_i` is 1, both the count and the divider phase hold, whatever the tick inputs do.
- R6: `tmr_clr_i` = 1 sets the count and the divider phase to 0 at the next edge. This takes priority over `pause_i` and over any tick.
- R7: Changes on `lim_i` and `div_i` have no effect until `upd_i` is pulsed. `upd_i` stages the values, and the staged values become active at the next wrap or clear. Activation also zeroes the divider phase.
- R8: Each wrap sets `ovf_raw_o` at the edge where the count returns to 0. `int_clr_i` = 1 resets the flag, but a wrap in the same cycle wins and leaves the flag set.
- R9: `ovf_st_o` is 1 exactly when `ovf_raw_o` and `int_en_i` are both 1.
- R10: `cnt_rd_o` always shows the value that `cnt_o` had one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fast_i | input | 1 | Fast tick enable source |
| tick_ref_i | input | 1 | Reference tick enable source |
| src_sel_i | input | 1 | Tick source select, 1 = fast |
| lim_i | input | 5 | Wrap exponent to be staged |
| div_i | input | 18 | Divide value to be staged, 8 fraction bits |
| pause_i | input | 1 | Hold count and phase |
| tmr_clr_i | input | 1 | Force count and phase to 0 |
| upd_i | input | 1 | Stage `lim_i` and `div_i` |
| int_en_i | input | 1 | Overflow status enable |
| int_clr_i | input | 1 | Overflow flag clear |
| cnt_o | output | 20 | Live count |
| cnt_rd_o | output | 20 | Count delayed by one cycle for register reads |
| ovf_raw_o | output | 1 | Sticky overflow flag |
| ovf_st_o | output | 1 | Masked overflow status |

## Verification
Two functions can land in the same cycle: a counter wrap that sets the overflow flag, and a software clear of that flag. The bench provokes this by holding the clear strobe high while the counter wraps every four ticks. It then requires the flag to read 1 on each cycle where the count has just returned to 0, and 0 on the other cycles. A second collision arises because the staged divide and exponent are activated at the wrap edge itself. A reference model runs cycle by cycle and compares every output on every clock, so an activation one cycle early or late shows up as a count mismatch.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
   // tick source encoding on the select input
   typedef enum logic {
      SRC_REF  = 1'b0,
      SRC_FAST = 1'b1
   } src_e;
endpackage

// File: rtl/pwmtb_cfg_stage.sv
module pwmtb_cfg_stage #(
   parameter int LIM_W  = 5,
   parameter int DIV_W  = 18,
   parameter int FRAC_W = 8,
   parameter int CNT_W  = 20,
   parameter bit STAGED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LIM_W-1:0] lim_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             upd_i,
   input  logic             wrap_i,
   input  logic             clr_i,
   output logic [LIM_W-1:0] act_lim_o,
   output logic [DIV_W-1:0] act_div_o,
   output logic             commit_o
);
   localparam logic [LIM_W-1:0] LIM_MAX = LIM_W'(CNT_W);
   localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1) << FRAC_W;

   logic [LIM_W-1:0] lim_clamped;
   assign lim_clamped = (lim_i > LIM_MAX) ? LIM_MAX : lim_i;

   generate
      if (STAGED) begin : g_staged
         logic [LIM_W-1:0] stg_lim_q, act_lim_q;
         logic [DIV_W-1:0] stg_div_q, act_div_q;
         logic             pend_q;
         logic             commit;

         assign commit = pend_q & (wrap_i | clr_i);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_lim_q <= LIM_MAX;
               stg_div_q <= DIV_ONE;
               act_lim_q <= LIM_MAX;
               act_div_q <= DIV_ONE;
               pend_q    <= 1'b0;
            end else begin
               if (commit) begin
                  act_lim_q <= stg_lim_q;
                  act_div_q <= stg_div_q;
               end
               if (upd_i) begin
                  stg_lim_q <= lim_clamped;
                  stg_div_q <= div_i;
                  pend_q    <= 1'b1;
               end else if (commit) begin
                  pend_q    <= 1'b0;
               end
            end
         end

         assign act_lim_o = act_lim_q;
         assign act_div_o = act_div_q;
         assign commit_o  = commit;
      end else begin : g_direct
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, upd_i, wrap_i, clr_i};
         assign act_lim_o = lim_clamped;
         assign act_div_o = div_i;
         assign commit_o  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwmtb_frac_div.sv
module pwmtb_frac_div #(
   parameter int DIV_W  = 18,
   parameter int FRAC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             hold_i,
   input  logic             clr_i,
   input  logic             rephase_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             en_o
);
   localparam int               ACC_W   = DIV_W + 1;
   localparam logic [ACC_W-1:0] ACC_ONE = ACC_W'(1) << FRAC_W;

   logic [DIV_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;
   logic [ACC_W-1:0] div_eff;
   logic             reach;
   logic             step;

   assign div_eff = ({1'b0, div_i} < ACC_ONE) ? ACC_ONE : {1'b0, div_i};
   assign acc_sum = {1'b0, acc_q} + ACC_ONE;
   assign reach   = acc_sum >= div_eff;
   assign step    = tick_i & ~hold_i & ~clr_i;
   assign en_o    = step & reach;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr_i || rephase_i) begin
         acc_q <= '0;
      end else if (step) begin
         if (reach) acc_q <= DIV_W'(acc_sum - div_eff);
         else       acc_q <= DIV_W'(acc_sum);
      end
   end
endmodule

// File: rtl/pwmtb_wrap_cnt.sv
module pwmtb_wrap_cnt #(
   parameter int CNT_W = 20,
   parameter int LIM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic [LIM_W-1:0] lim_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] top_val;

   assign top_val = (lim_i >= LIM_W'(CNT_W)) ? '1
                  : ((CNT_W'(1) << lim_i) - CNT_W'(1));
   assign wrap_o  = en_i & ~clr_i & (cnt_q == top_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (wrap_o)  cnt_q <= '0;
      else if (en_i)    cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/pwmtb_ovf_irq.sv
module pwmtb_ovf_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap_i,
   input  logic clr_i,
   input  logic en_i,
   output logic raw_o,
   output logic st_o
);
   logic raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      raw_q <= 1'b0;
      else if (wrap_i) raw_q <= 1'b1;
      else if (clr_i)  raw_q <= 1'b0;
   end

   assign raw_o = raw_q;
   assign st_o  = raw_q & en_i;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W  = 20,
   parameter int LIM_W  = 5,
   parameter int DIV_W  = 18,
   parameter int FRAC_W = 8,
   parameter bit STAGED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_fast_i,
   input  logic             tick_ref_i,
   input  logic             src_sel_i,
   input  logic [LIM_W-1:0] lim_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             pause_i,
   input  logic             tmr_clr_i,
   input  logic             upd_i,
   input  logic             int_en_i,
   input  logic             int_clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_rd_o,
   output logic             ovf_raw_o,
   output logic             ovf_st_o
);
   import pwmtb_pkg::*;

   generate
      if (CNT_W >= (1 << LIM_W)) begin : g_bad_lim
         $error("LIM_W too narrow for CNT_W");
      end
      if (FRAC_W >= DIV_W) begin : g_bad_frac
         $error("FRAC_W must be below DIV_W");
      end
   endgenerate

   src_e             src_sel;
   logic             tick;
   logic [LIM_W-1:0] act_lim;
   logic [DIV_W-1:0] act_div;
   logic             commit;
   logic             cnt_en;
   logic             wrap;
   logic [CNT_W-1:0] cnt_rd_q;

   assign src_sel = src_e'(src_sel_i);
   assign tick    = (src_sel == SRC_FAST) ? tick_fast_i : tick_ref_i;

   pwmtb_cfg_stage #(
      .LIM_W(LIM_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W),
      .CNT_W(CNT_W), .STAGED(STAGED)
   ) u_stage (
      .clk(clk), .rst_n(rst_n), .lim_i(lim_i), .div_i(div_i),
      .upd_i(upd_i), .wrap_i(wrap), .clr_i(tmr_clr_i),
      .act_lim_o(act_lim), .act_div_o(act_div), .commit_o(commit)
   );

   pwmtb_frac_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_i(pause_i),
      .clr_i(tmr_clr_i), .rephase_i(commit), .div_i(act_div), .en_o(cnt_en)
   );

   pwmtb_wrap_cnt #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en_i(cnt_en), .clr_i(tmr_clr_i),
      .lim_i(act_lim), .cnt_o(cnt_o), .wrap_o(wrap)
   );

   pwmtb_ovf_irq u_irq (
      .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .clr_i(int_clr_i),
      .en_i(int_en_i), .raw_o(ovf_raw_o), .st_o(ovf_st_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_rd_q <= '0;
      else        cnt_rd_q <= cnt_o;
   end
   assign cnt_rd_o = cnt_rd_q;
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
   parameter int CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pause_i,
   input logic             tmr_clr_i,
   input logic             int_en_i,
   input logic             int_clr_i,
   input logic [CNT_W-1:0] cnt_o,
   input logic [CNT_W-1:0] cnt_rd_o,
   input logic             ovf_raw_o,
   input logic             ovf_st_o
);
   AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_i && !tmr_clr_i) |=> $stable(cnt_o));                          // R5
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_clr_i |=> (cnt_o == '0));                                         // R6
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt_o) && cnt_o != '0) |-> (cnt_o == $past(cnt_o) + 1'b1)); // R3
   AST_RAW_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_raw_o) |-> (cnt_o == '0));                                  // R8
   AST_CLR_WINS_ONLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      int_clr_i |=> (!ovf_raw_o || cnt_o == '0));                           // R8
   AST_ST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_raw_o || !int_en_i) |-> !ovf_st_o);                             // R9
   AST_RD_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_rd_o == $past(cnt_o)));                                 // R10
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pause_i(pause_i), .tmr_clr_i(tmr_clr_i),
   .int_en_i(int_en_i), .int_clr_i(int_clr_i), .cnt_o(cnt_o),
   .cnt_rd_o(cnt_rd_o), .ovf_raw_o(ovf_raw_o), .ovf_st_o(ovf_st_o)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_fast_i = 1'b0, tick_ref_i = 1'b0, src_sel_i = 1'b1;
   logic [4:0]  lim_i = 5'd0;
   logic [17:0] div_i = 18'd0;
   logic        pause_i = 1'b0, tmr_clr_i = 1'b0, upd_i = 1'b0;
   logic        int_en_i = 1'b0, int_clr_i = 1'b0;
   logic [19:0] cnt_o, cnt_rd_o;
   logic        ovf_raw_o, ovf_st_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   // reference model state
   int m_acc, m_cnt, m_rd, m_raw;
   int m_alim, m_adiv, m_slim, m_sdiv, m_pend;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_timebase u_dut (
      .clk(clk), .rst_n(rst_n), .tick_fast_i(tick_fast_i), .tick_ref_i(tick_ref_i),
      .src_sel_i(src_sel_i), .lim_i(lim_i), .div_i(div_i), .pause_i(pause_i),
      .tmr_clr_i(tmr_clr_i), .upd_i(upd_i), .int_en_i(int_en_i),
      .int_clr_i(int_clr_i), .cnt_o(cnt_o), .cnt_rd_o(cnt_rd_o),
      .ovf_raw_o(ovf_raw_o), .ovf_st_o(ovf_st_o)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_acc = 0; m_cnt = 0; m_rd = 0; m_raw = 0;
         m_alim = 20; m_adiv = 256; m_slim = 20; m_sdiv = 256; m_pend = 0;
      end else begin
         int  tk, eff, nxt, en, wr, cm;
         tk  = src_sel_i ? int'(tick_fast_i) : int'(tick_ref_i);
         eff = (m_adiv < 256) ? 256 : m_adiv;
         en = 0; wr = 0;
         m_rd = m_cnt;
         if (tmr_clr_i) begin
            m_cnt = 0; m_acc = 0;
         end else if (!pause_i && tk == 1) begin
            nxt = m_acc + 256;
            if (nxt >= eff) begin m_acc = nxt - eff; en = 1; end
            else m_acc = nxt;
         end
         if (en == 1) begin
            if (m_cnt == (1 << m_alim) - 1) begin m_cnt = 0; wr = 1; end
            else m_cnt = m_cnt + 1;
         end
         cm = ((wr == 1 || tmr_clr_i) && m_pend == 1) ? 1 : 0;
         if (cm == 1) begin m_alim = m_slim; m_adiv = m_sdiv; m_acc = 0; end
         if (upd_i) begin
            m_slim = (lim_i > 20) ? 20 : int'(lim_i);
            m_sdiv = int'(div_i); m_pend = 1;
         end else if (cm == 1) m_pend = 0;
         if (wr == 1) m_raw = 1;
         else if (int_clr_i) m_raw = 0;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 count", int'(cnt_o), m_cnt);
         chk("R10 read copy", int'(cnt_rd_o), m_rd);
         chk("R8 raw flag", int'(ovf_raw_o), m_raw);
         chk("R9 status", int'(ovf_st_o), (m_raw == 1 && int_en_i) ? 1 : 0);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic cyc(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic program_cfg(int lim, int dv);
      lim_i = 5'(lim); div_i = 18'(dv); upd_i = 1'b1;
      cyc();
      upd_i = 1'b0; tmr_clr_i = 1'b1;
      cyc();
      tmr_clr_i = 1'b0;
   endtask

   initial begin
      int prev;
      cyc(2);
      // R1: reset values
      chk("R1 count", int'(cnt_o), 0);
      chk("R1 raw", int'(ovf_raw_o), 0);
      chk("R1 status", int'(ovf_st_o), 0);
      rst_n = 1'b1;
      cyc();
      chk("R1 read copy", int'(cnt_rd_o), 0);

      // R4: exponent 3, divide 1.0, wrap after 7
      program_cfg(3, 256);
      src_sel_i = 1'b1; tick_fast_i = 1'b1;
      cyc(7);
      chk("R4 top value", int'(cnt_o), 7);
      chk("R8 no flag before wrap", int'(ovf_raw_o), 0);
      cyc();
      chk("R4 wrap to zero", int'(cnt_o), 0);
      chk("R8 flag on wrap", int'(ovf_raw_o), 1);
      tick_fast_i = 1'b0;

      // R9: mask
      chk("R9 masked", int'(ovf_st_o), 0);
      int_en_i = 1'b1;
      #1 chk("R9 enabled", int'(ovf_st_o), 1);
      int_clr_i = 1'b1;
      cyc();
      int_clr_i = 1'b0;
      chk("R8 clear", int'(ovf_raw_o), 0);

      // R2: unselected source ignored
      src_sel_i = 1'b1; tick_ref_i = 1'b1;
      cyc(5);
      chk("R2 ref ignored when fast chosen", int'(cnt_o), 0);
      src_sel_i = 1'b0;
      cyc(3);
      chk("R2 ref counts when chosen", int'(cnt_o), 3);

      // R5: pause holds
      pause_i = 1'b1;
      cyc(5);
      chk("R5 paused", int'(cnt_o), 3);
      // R6: clear beats pause
      tmr_clr_i = 1'b1;
      cyc();
      tmr_clr_i = 1'b0; pause_i = 1'b0; tick_ref_i = 1'b0;
      chk("R6 clear over pause", int'(cnt_o), 0);

      // R3: divide by 2.5 over 100 ticks
      program_cfg(20, 640);
      src_sel_i = 1'b1; tick_fast_i = 1'b1;
      cyc(100);
      chk("R3 fractional 2.5", int'(cnt_o), 40);

      // R7: input changes without strobe have no effect
      lim_i = 5'd2; div_i = 18'd256;
      cyc(20);
      chk("R7 no strobe", int'(cnt_o), 48);
      upd_i = 1'b1;
      cyc();
      upd_i = 1'b0;
      cyc(9);
      chk("R7 staged not yet active", int'(cnt_o), 52);
      tmr_clr_i = 1'b1;
      cyc();
      tmr_clr_i = 1'b0;
      cyc(3);
      chk("R7 active after clear", int'(cnt_o), 3);
      cyc();
      chk("R4 exponent 2 wrap", int'(cnt_o), 0);

      // R8: flag clear held across wraps, wrap wins
      int_clr_i = 1'b1;
      for (int k = 0; k < 12; k++) begin
         cyc();
         if (cnt_o == 20'd0) chk("R8 wrap beats clear", int'(ovf_raw_o), 1);
         else                chk("R8 clear between wraps", int'(ovf_raw_o), 0);
      end
      int_clr_i = 1'b0;

      // R3: divide below 1.0 behaves as 1.0
      program_cfg(20, 100);
      cyc(10);
      chk("R3 small divide", int'(cnt_o), 10);

      // R4: exponent 0 keeps the count at 0
      program_cfg(0, 256);
      int_clr_i = 1'b1; cyc(); int_clr_i = 1'b0;
      cyc(4);
      chk("R4 exponent 0", int'(cnt_o), 0);
      chk("R8 exponent 0 wraps", int'(ovf_raw_o), 1);

      // R10: read copy lags one cycle
      program_cfg(20, 256);
      cyc(3);
      prev = int'(cnt_o);
      cyc();
      chk("R10 lag", int'(cnt_rd_o), prev);
      tick_fast_i = 1'b0;

      cyc(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule